// File: doc/BRIEF.md
# Delayed-Response Foraging Judge

This block scores an agent in a grid-foraging task, one sensor-motor step at a time. On each step it receives the four motor command bits (forward, turn left, turn right, mouth close), a flag saying that the agent's current cell holds a resource, and a flag saying whether that resource is food or poison. It keeps track of how many consecutive steps the agent has stood still on the resource. It rules on whether a mouth closure is a valid meal, and it keeps a signed fitness score and a remaining-lifespan count.

A meal counts only after a precise delay. The agent must stay motionless on the resource for exactly K steps and close its mouth on the last of those steps. Waiting steps cost no lifespan. Every other step uses up one unit of the budget, and the run ends when the budget reaches zero. A start pulse samples K and the budget from input pins and opens a run. When a meal is credited, the block emits a one-cycle pulse that the surrounding world model uses to clear the resource from the cell.

Top module: `forage_judge`

## Requirements
- R1: A start pulse loads K from `kIn`, with a value of 0 taken as 1. It loads the budget from `lifeIn`, clears fitness and the wait count, and sets `running`. If `lifeIn` is 0, it sets `done` instead of `running`.
- R2: A waiting step is a step with `resHere`=1 and none of `mvFwd`, `turnLeft` or `turnRight` set.
  - A waiting step raises `waitCnt` by one, saturating at K+1.
  - Any other step clears `waitCnt` to 0.
- R3: A waiting step with `mouthClose`=1 is a meal when `waitCnt` before the step equals K-1, so that this step is the K-th.
  - In the cycle after such a step, `eatPls` is 1.
  - `eatFood` copies `resIsFood` (1 = food, 0 = poison).
  - `waitCnt` is 0.
- R4: A mouth closure on any step that is not a meal changes neither `fitness` nor `eatPls`. This covers closures on non-waiting steps and on waiting steps after fewer or more than K steps.
- R5: A food meal adds 1 to `fitness` and a poison meal subtracts 1. `fitness` is two's complement and saturates at 32767 and -32768.
- R6: A non-waiting step lowers `lifeLeft` by 1. A waiting step leaves `lifeLeft` unchanged.
- R7: When `lifeLeft` reaches 0, `done` rises and `running` falls. From then on, steps change no output until the next start pulse.
- R8: After reset and before the first start pulse, `running` and `done` are 0, and steps change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPls | input | 1 | Begin a run; samples `kIn` and `lifeIn` |
| kIn | input | KW | Required number of waiting steps |
| lifeIn | input | LW | Lifespan step budget |
| stepVld | input | 1 | One sensor-motor step is presented this cycle |
| mvFwd | input | 1 | Forward move command |
| turnLeft | input | 1 | Left turn command |
| turnRight | input | 1 | Right turn command |
| mouthClose | input | 1 | Mouth close command |
| resHere | input | 1 | Current cell holds a resource |
| resIsFood | input | 1 | Resource is food (1) or poison (0) |
| eatPls | output | 1 | A meal was credited on the previous step; clear the cell |
| eatFood | output | 1 | Kind of the credited meal, valid with `eatPls` |
| fitness | output | FW | Signed score, food minus poison |
| lifeLeft | output | LW | Remaining lifespan budget |
| waitCnt | output | KW+1 | Consecutive waiting steps, saturating at K+1 |
| running | output | 1 | A run is in progress |
| done | output | 1 | Lifespan exhausted |

## Verification
The assertions check the following on every cycle:
- the wait count never exceeds K+1;
- a waiting step never moves the lifespan count;
- a credit moves fitness by exactly one unless fitness is already at its limit;
- a meal pulse always leaves the wait count at zero;
- the done state persists until a new start;
- food and poison credits never coincide.

Some behaviour only the bench's scenarios can show. This covers the exact count at which a closure is accepted, the rejection of closures one step early or late, saturation of fitness after tens of thousands of meals, and the K-of-zero clamp. It also covers the silence of the block before the first start and after the budget runs out.

// File: rtl/forage_pkg.sv
package forage_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } judgeState_t;

  typedef struct packed {
    logic loadCfg;
    logic incWait;
    logic clearWait;
    logic burnLife;
    logic creditFood;
    logic creditPoison;
  } judgeStrobe_t;

endpackage

// File: rtl/forage_ctrl.sv
module forage_ctrl
  import forage_pkg::*;
#(
  parameter int KW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startPls,
  input  logic          lifeInZero,
  input  logic          stepVld,
  input  logic          mvFwd,
  input  logic          turnLeft,
  input  logic          turnRight,
  input  logic          mouthClose,
  input  logic          resHere,
  input  logic          resIsFood,
  input  logic [KW:0]   waitCnt,
  input  logic [KW:0]   kVal,
  input  logic          lifeLast,
  output judgeStrobe_t  strobe,
  output logic          running,
  output logic          done
);

  judgeState_t state, stateNxt;
  logic anyMove;
  logic waitStep;
  logic hitCount;
  logic mealNow;

  assign anyMove  = mvFwd | turnLeft | turnRight;
  assign waitStep = resHere & ~anyMove;
  assign hitCount = ((waitCnt + 1'b1) == kVal);
  assign mealNow  = waitStep & mouthClose & hitCount;

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    if (startPls) begin
      strobe.loadCfg = 1'b1;
      stateNxt       = lifeInZero ? ST_DONE : ST_RUN;
    end else if (state == ST_RUN && stepVld) begin
      if (waitStep) begin
        if (mealNow) begin
          strobe.clearWait    = 1'b1;
          strobe.creditFood   = resIsFood;
          strobe.creditPoison = ~resIsFood;
        end else begin
          strobe.incWait = 1'b1;
        end
      end else begin
        strobe.clearWait = 1'b1;
        strobe.burnLife  = 1'b1;
        if (lifeLast) stateNxt = ST_DONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign running = (state == ST_RUN);
  assign done    = (state == ST_DONE);

  // R7: the exhausted state is left only through a start pulse
  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startPls) |=> done);

  // R5: never credit food and poison together
  a_r5_single_credit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.creditFood, strobe.creditPoison}));

  // R8: idle state issues no step strobes
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !startPls) |-> (strobe == '0));

endmodule

// File: rtl/forage_dp.sv
module forage_dp
  import forage_pkg::*;
#(
  parameter int KW = 8,
  parameter int LW = 16,
  parameter int FW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  judgeStrobe_t         strobe,
  input  logic [KW-1:0]        kIn,
  input  logic [LW-1:0]        lifeIn,
  input  logic                 resIsFood,
  output logic [KW:0]          waitCnt,
  output logic [KW:0]          kVal,
  output logic                 lifeLast,
  output logic [LW-1:0]        lifeLeft,
  output logic signed [FW-1:0] fitness,
  output logic                 eatPls,
  output logic                 eatFood
);

  localparam logic signed [FW-1:0] FIT_MAX = {1'b0, {(FW-1){1'b1}}};
  localparam logic signed [FW-1:0] FIT_MIN = {1'b1, {(FW-1){1'b0}}};

  logic [KW:0] kClamped;
  logic        waitFull;

  assign kClamped = (kIn == '0) ? {{KW{1'b0}}, 1'b1} : {1'b0, kIn};
  assign waitFull = (waitCnt > kVal);
  assign lifeLast = (lifeLeft == {{(LW-1){1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kVal <= {{KW{1'b0}}, 1'b1};
    end else if (strobe.loadCfg) begin
      kVal <= kClamped;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strobe.loadCfg || strobe.clearWait) begin
      waitCnt <= '0;
    end else if (strobe.incWait && !waitFull) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lifeLeft <= '0;
    end else if (strobe.loadCfg) begin
      lifeLeft <= lifeIn;
    end else if (strobe.burnLife && lifeLeft != '0) begin
      lifeLeft <= lifeLeft - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fitness <= '0;
    end else if (strobe.loadCfg) begin
      fitness <= '0;
    end else if (strobe.creditFood && fitness != FIT_MAX) begin
      fitness <= fitness + 1'b1;
    end else if (strobe.creditPoison && fitness != FIT_MIN) begin
      fitness <= fitness - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eatPls  <= 1'b0;
      eatFood <= 1'b0;
    end else begin
      eatPls <= strobe.creditFood | strobe.creditPoison;
      if (strobe.creditFood | strobe.creditPoison) eatFood <= resIsFood;
    end
  end

  // R2: the wait count never passes K+1
  a_r2_wait_bound: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= kVal + 1'b1);

  // R6: a waiting step leaves the budget alone
  a_r6_wait_keeps_life: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incWait |=> $stable(lifeLeft));

  // R5: a food credit moves the score up by one below the ceiling
  a_r5_food_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.creditFood && fitness != FIT_MAX) |=> fitness == $past(fitness) + 1'b1);

  // R5: a poison credit moves the score down by one above the floor
  a_r5_poison_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.creditPoison && fitness != FIT_MIN) |=> fitness == $past(fitness) - 1'b1);

  // R3: a meal pulse comes with an emptied wait count
  a_r3_eat_clears: assert property (@(posedge clk) disable iff (!rstN)
    eatPls |-> waitCnt == '0);

endmodule

// File: rtl/forage_judge.sv
module forage_judge
  import forage_pkg::*;
#(
  parameter int KW = 8,
  parameter int LW = 16,
  parameter int FW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startPls,
  input  logic [KW-1:0]        kIn,
  input  logic [LW-1:0]        lifeIn,
  input  logic                 stepVld,
  input  logic                 mvFwd,
  input  logic                 turnLeft,
  input  logic                 turnRight,
  input  logic                 mouthClose,
  input  logic                 resHere,
  input  logic                 resIsFood,
  output logic                 eatPls,
  output logic                 eatFood,
  output logic signed [FW-1:0] fitness,
  output logic [LW-1:0]        lifeLeft,
  output logic [KW:0]          waitCnt,
  output logic                 running,
  output logic                 done
);

  judgeStrobe_t strobe;
  logic [KW:0]  kVal;
  logic         lifeLast;

  forage_ctrl #(.KW(KW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPls   (startPls),
    .lifeInZero (lifeIn == '0),
    .stepVld    (stepVld),
    .mvFwd      (mvFwd),
    .turnLeft   (turnLeft),
    .turnRight  (turnRight),
    .mouthClose (mouthClose),
    .resHere    (resHere),
    .resIsFood  (resIsFood),
    .waitCnt    (waitCnt),
    .kVal       (kVal),
    .lifeLast   (lifeLast),
    .strobe     (strobe),
    .running    (running),
    .done       (done)
  );

  forage_dp #(.KW(KW), .LW(LW), .FW(FW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .kIn       (kIn),
    .lifeIn    (lifeIn),
    .resIsFood (resIsFood),
    .waitCnt   (waitCnt),
    .kVal      (kVal),
    .lifeLast  (lifeLast),
    .lifeLeft  (lifeLeft),
    .fitness   (fitness),
    .eatPls    (eatPls),
    .eatFood   (eatFood)
  );

endmodule

// File: tb/test_forage_judge.sv
module test_forage_judge;

  localparam int KW = 8;
  localparam int LW = 16;
  localparam int FW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPls = 1'b0;
  logic [KW-1:0] kIn = '0;
  logic [LW-1:0] lifeIn = '0;
  logic stepVld = 1'b0, mvFwd = 1'b0, turnLeft = 1'b0, turnRight = 1'b0;
  logic mouthClose = 1'b0, resHere = 1'b0, resIsFood = 1'b0;
  logic eatPls, eatFood, running, done;
  logic signed [FW-1:0] fitness;
  logic [LW-1:0] lifeLeft;
  logic [KW:0] waitCnt;

  int vectors = 0;
  int fails = 0;

  // reference state, built from the requirements
  int  mK, mWait, mLife, mFit;
  bit  mRun, mDone, mEat, mFood;

  always #4 clk = ~clk;

  forage_judge #(.KW(KW), .LW(LW), .FW(FW)) i_forage_judge (.*);

  function automatic int satFit(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int nextWait(input int w, input int k);
    return (w + 1 > k + 1) ? k + 1 : w + 1;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    chk(req, "waitCnt", int'(waitCnt), mWait);
    chk(req, "lifeLeft", int'(lifeLeft), mLife);
    chk(req, "fitness", int'(fitness), mFit);
    chk(req, "running", int'(running), int'(mRun));
    chk(req, "done", int'(done), int'(mDone));
    chk(req, "eatPls", int'(eatPls), int'(mEat));
    if (mEat) chk(req, "eatFood", int'(eatFood), int'(mFood));
  endtask

  task automatic doStart(input int k, input int life, input string req);
    kIn = KW'(k); lifeIn = LW'(life); startPls = 1'b1;
    @(negedge clk);
    startPls = 1'b0;
    mK = (k == 0) ? 1 : k; mLife = life; mWait = 0; mFit = 0; mEat = 0;
    mRun = (life != 0); mDone = (life == 0);
    checkAll(req);
  endtask

  task automatic doStep(input bit f, input bit l, input bit r, input bit m,
                        input bit res, input bit food, input string req);
    bit waitStep;
    mvFwd = f; turnLeft = l; turnRight = r; mouthClose = m;
    resHere = res; resIsFood = food; stepVld = 1'b1;
    mEat = 0;
    if (mRun) begin
      waitStep = res && !f && !l && !r;
      if (waitStep) begin
        if (m && (mWait + 1 == mK)) begin
          mEat = 1; mFood = food; mWait = 0;
          mFit = satFit(mFit + (food ? 1 : -1));
        end else begin
          mWait = nextWait(mWait, mK);
        end
      end else begin
        mWait = 0;
        mLife = mLife - 1;
        if (mLife == 0) begin mRun = 0; mDone = 1; end
      end
    end
    @(negedge clk);
    stepVld = 1'b0;
    checkAll(req);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    mK = 1; mWait = 0; mLife = 0; mFit = 0; mRun = 0; mDone = 0; mEat = 0; mFood = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R8 reset");

    // R8: steps before any start are ignored
    doStep(1, 0, 0, 1, 1, 1, "R8");
    doStep(0, 0, 0, 1, 1, 1, "R8");

    // R1: K of zero acts as one
    doStart(0, 20, "R1");
    doStep(0, 0, 0, 1, 1, 1, "R1 k0 meal R3");

    // R3/R4: K = 3, closing early, exactly, late
    doStart(3, 50, "R1");
    doStep(0, 0, 0, 0, 1, 1, "R2");
    doStep(0, 0, 0, 1, 1, 1, "R4 early");
    doStep(0, 0, 0, 1, 1, 1, "R3 exact");
    for (int i = 0; i < 3; i++) doStep(0, 0, 0, 0, 1, 0, "R2");
    doStep(0, 0, 0, 1, 1, 0, "R4 late");
    doStep(0, 1, 0, 0, 1, 0, "R2 turn clears R6");
    doStep(0, 0, 0, 1, 0, 1, "R4 no resource");
    doStep(0, 0, 0, 0, 1, 0, "R2");
    doStep(0, 0, 0, 0, 1, 0, "R2");
    doStep(0, 0, 0, 1, 1, 0, "R3 poison R5");

    // R2: long wait saturates at K+1 and never looks valid again
    doStart(2, 30, "R1");
    for (int i = 0; i < 300; i++) doStep(0, 0, 0, 0, 1, 1, "R2 sat R6");
    doStep(0, 0, 0, 1, 1, 1, "R4 after sat");

    // R7: budget exhaustion, then ignored steps
    doStart(2, 3, "R1");
    doStep(1, 0, 0, 0, 0, 0, "R6");
    doStep(0, 0, 1, 0, 1, 0, "R6");
    doStep(1, 0, 0, 1, 1, 1, "R7 last");
    doStep(0, 0, 0, 1, 1, 1, "R7 ignored");
    doStep(1, 0, 0, 0, 0, 0, "R7 ignored");
    doStart(4, 0, "R1 zero budget R7");
    doStep(0, 0, 0, 1, 1, 1, "R7 ignored");

    // random stimulus
    for (int run = 0; run < 20; run++) begin
      doStart(int'($urandom_range(0, 4)), int'($urandom_range(5, 60)), "R1");
      for (int s = 0; s < 200; s++) begin
        bit mv;
        mv = ($urandom_range(0, 9) == 0);
        doStep(mv & $urandom_range(0, 1), mv & $urandom_range(0, 1), mv,
               $urandom_range(0, 2) == 0, $urandom_range(0, 7) != 0,
               $urandom_range(0, 1) == 1, "R2 R3 R4 R6 random");
      end
    end

    // R5: saturation at both limits
    doStart(1, 10, "R1");
    for (int i = 0; i < 32770; i++) doStep(0, 0, 0, 1, 1, 1, "R5 ceiling");
    for (int i = 0; i < 65540; i++) doStep(0, 0, 0, 1, 1, 0, "R5 floor");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule